// File: doc/BRIEF.md
# Guarded Byte EEPROM Write Controller

This block places a byte-wide nonvolatile store of 2^ADDR_W entries behind four registers on a simple processor register bus. Software selects a location in an address register. It moves bytes through a data register and steers the block through a control register that holds read, write-enable, write-go, error and done bits. A fourth register accepts only writes and serves as an unlock port.

A read takes one cycle. Setting the read bit copies the addressed byte into the data register at the next clock edge.

A write is deliberately hard to trigger by accident, and three things must all be true for one to start:
- Software writes 55h to the unlock port, then AAh, then the go bit, on three back-to-back bus cycles.
- The write-enable bit was already set before the go write.
- The power-up lockout window that follows reset has ended.

A started write runs for a fixed, parameterised number of cycles. It then commits the byte, drops the go bit and raises a sticky done flag, which also drives an interrupt pin.

Top module: `ee_guard_ctrl`

## Requirements
- R1: After reset the address, data and control registers read 00h, done_irq is low, and every storage byte holds FFh (erased).
- R2: Register select codes are 0 address, 1 data, 2 control, 3 unlock port. Control bits are 0 read, 1 write-enable, 2 go/busy, 3 error, 4 done. Writing the control register with bit 0 set loads the byte at the current address into the data register, readable on the next cycle. Bit 0 always reads 0.
- R3: The data register keeps its value until the next read request or a direct software write to it; changing the address alone leaves it unchanged.
- R4: A go request is refused unless write-enable was 1 before the control write that carries it; setting both bits in one write starts nothing.
- R5: A write starts only when 55h and then AAh are written to the unlock port and the go bit is written, on three consecutive cycles; any other order, an idle cycle or any other access in between refuses the go.
- R6: The go bit reads 1 from the cycle after the accepted go write for WR_CYCLES cycles, so done becomes visible exactly WR_CYCLES cycles after that write; the data register byte is then stored at the address.
- R7: Done sets when a write finishes, drives done_irq, and stays set until software writes 1 to control bit 4 (writing 1 to bit 3 clears error).
- R8: Write-enable changes only by software writes; clearing it during a write does not abort the write, and completion does not clear it.
- R9: For PWRUP_CYCLES cycles after reset every go request is refused even with a correct unlock sequence.
- R10: While a write is in progress, writes to the address or data register and read requests are ignored and set the error bit.
- R11: The unlock port always reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_reg | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| done_irq | output | 1 | Level interrupt, copy of the done bit |

## Verification
The bench attacks the unlock path with keys reversed, an idle cycle between keys, a read between keys, and enable and go set in the same write; a design with a loose sequence checker would commit a byte in one of those cases. It times the write exactly from the go write to done, which catches an off-by-one in the counter. It disturbs the address, data, read bit and enable bit mid-write: a design that let these through would store the wrong byte, lose the data register or abort. It also tries a full correct sequence during the lockout window, where a missing lockout would overwrite an erased byte.

// File: rtl/ee_guard_pkg.sv
package ee_guard_pkg;

   typedef enum logic [1:0] {
      REG_ADDR = 2'd0,
      REG_DATA = 2'd1,
      REG_CTRL = 2'd2,
      REG_KEY  = 2'd3
   } reg_sel_e;

   localparam int CTRL_RD   = 0;
   localparam int CTRL_WEN  = 1;
   localparam int CTRL_GO   = 2;
   localparam int CTRL_ERR  = 3;
   localparam int CTRL_DONE = 4;
   localparam int CTRL_BITS = 5;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_HALF  = 2'd1,
      UL_ARMED = 2'd2
   } unlock_e;

endpackage

// File: rtl/ee_unlock_seq.sv
module ee_unlock_seq
   import ee_guard_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              armed
);

   localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

   unlock_e state, state_nx;

   always_comb begin
      state_nx = UL_IDLE;
      if (key_wr && key_data == K1) begin
         state_nx = UL_HALF;
      end else if (state == UL_HALF && key_wr && key_data == K2) begin
         state_nx = UL_ARMED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= UL_IDLE;
      end else begin
         state <= state_nx;
      end
   end

   assign armed = (state == UL_ARMED);

   // R5
   armed_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == UL_ARMED) |-> ($past(state) == UL_HALF && $past(key_wr)));

   // R5
   armed_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> !armed);

endmodule

// File: rtl/ee_cycle_timer.sv
module ee_cycle_timer #(
   parameter int CYCLES     = 16,
   parameter bit FROM_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);

   localparam int            CW   = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("ee_cycle_timer: CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   generate
      if (FROM_RESET) begin : g_boot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= LOAD;
            end else if (cnt != '0) begin
               cnt <= cnt - ONE;
            end
         end
      end else begin : g_trig
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (cnt != '0) begin
               cnt <= cnt - ONE;
            end else if (start) begin
               cnt <= LOAD;
            end
         end
      end
   endgenerate

   assign busy = (cnt != '0);
   assign last = (cnt == ONE);

   // R6
   end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);

   // R6
   start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !FROM_RESET) |=> busy);

endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter bit ERASED_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (ERASED_RESET) begin : g_erased
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  mem[i] <= '1;
               end
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = mem[raddr];

   // R6
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ee_guard_ctrl.sv
module ee_guard_ctrl
   import ee_guard_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int WR_CYCLES    = 16000,
   parameter int PWRUP_CYCLES = 64000,
   parameter bit ERASED_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [1:0]        bus_reg,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              done_irq
);

   localparam int PAD_W = DATA_W - CTRL_BITS;

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("ee_guard_ctrl: DATA_W must be at least 8");
      end
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_aw
         $error("ee_guard_ctrl: ADDR_W must lie in 1..DATA_W");
      end
   endgenerate

   reg_sel_e sel_e;
   logic     wr_acc, addr_wr, data_wr, ctrl_wr, key_wr;
   logic     rd_req, go_req, start_ok, err_set;
   logic     armed, wr_busy, wr_last, lock_busy, lock_last;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, mem_rdata;
   logic              wen_q, err_q, done_q;

   assign sel_e   = reg_sel_e'(bus_reg);
   assign wr_acc  = bus_sel && bus_we;
   assign addr_wr = wr_acc && (sel_e == REG_ADDR);
   assign data_wr = wr_acc && (sel_e == REG_DATA);
   assign ctrl_wr = wr_acc && (sel_e == REG_CTRL);
   assign key_wr  = wr_acc && (sel_e == REG_KEY);

   assign rd_req   = ctrl_wr && bus_wdata[CTRL_RD];
   assign go_req   = ctrl_wr && bus_wdata[CTRL_GO];
   assign start_ok = go_req && armed && wen_q && !lock_busy && !wr_busy;
   assign err_set  = wr_busy && (addr_wr || data_wr || rd_req);

   ee_unlock_seq #(
      .DATA_W (DATA_W)
   ) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (bus_wdata),
      .armed    (armed)
   );

   ee_cycle_timer #(
      .CYCLES     (WR_CYCLES),
      .FROM_RESET (1'b0)
   ) u_wr_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_ok),
      .busy  (wr_busy),
      .last  (wr_last)
   );

   ee_cycle_timer #(
      .CYCLES     (PWRUP_CYCLES),
      .FROM_RESET (1'b1)
   ) u_lock_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (1'b0),
      .busy  (lock_busy),
      .last  (lock_last)
   );

   ee_byte_store #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .ERASED_RESET (ERASED_RESET)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_last),
      .waddr (addr_q),
      .wdata (data_q),
      .raddr (addr_q),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_wr && !wr_busy) begin
         addr_q <= bus_wdata[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_req && !wr_busy) begin
         data_q <= mem_rdata;
      end else if (data_wr && !wr_busy) begin
         data_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q  <= 1'b0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            wen_q <= bus_wdata[CTRL_WEN];
         end
         if (err_set) begin
            err_q <= 1'b1;
         end else if (ctrl_wr && bus_wdata[CTRL_ERR]) begin
            err_q <= 1'b0;
         end
         if (wr_last) begin
            done_q <= 1'b1;
         end else if (ctrl_wr && bus_wdata[CTRL_DONE]) begin
            done_q <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (sel_e)
         REG_ADDR: bus_rdata = DATA_W'(addr_q);
         REG_DATA: bus_rdata = data_q;
         REG_CTRL: bus_rdata = {{PAD_W{1'b0}}, done_q, err_q, wr_busy, wen_q, 1'b0};
         default:  bus_rdata = '0;
      endcase
   end

   assign done_irq = done_q;

   // R4
   go_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(wen_q));

   // R5
   go_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(armed));

   // R9
   go_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> !$past(lock_busy));

   // R9
   lock_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_last |=> !lock_busy);

   // R6
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> done_q);

   // R7
   done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(ctrl_wr && bus_wdata[CTRL_DONE])) |=> done_q);

   // R8
   wen_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wen_q != $past(wen_q)) |-> $past(ctrl_wr));

   // R10
   addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |=> $stable(addr_q));

   // R10
   data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |=> $stable(data_q));

   // R10
   err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> err_q);

endmodule

// File: tb/tb_ee_guard_ctrl.sv
module tb_ee_guard_ctrl;

   localparam int W  = 20;
   localparam int P  = 40;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [1:0]    bus_reg = 2'd0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          done_irq;

   ee_guard_ctrl #(
      .ADDR_W       (8),
      .DATA_W       (DW),
      .WR_CYCLES    (W),
      .PWRUP_CYCLES (P),
      .ERASED_RESET (1'b1)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_reg   (bus_reg),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .done_irq  (done_irq)
   );

   always #4 clk = ~clk;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   ended = 1'b0;

   localparam logic [1:0] A_ADDR = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_CTRL = 2'd2;
   localparam logic [1:0] A_KEY  = 2'd3;

   task automatic bus_write(input logic [1:0] r, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_reg = r; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_expect(input logic [1:0] r, input logic [DW-1:0] e, input string tag);
      exp_t it;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      bus_sel = 1'b1; bus_we = 1'b0; bus_reg = r;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: pops the expected item for every read it sees on the bus
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (bus_sel && !bus_we) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
               n_bad++;
               $display("FAIL scoreboard: unexpected read, got %02h expected none", bus_rdata);
            end else begin
               exp_t it;
               it = sb_q.pop_front();
               if (bus_rdata !== it.exp) begin
                  n_bad++;
                  $display("FAIL %s: got %02h expected %02h", it.tag, bus_rdata, it.exp);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog: got hung run expected completion");
      finish_run();
   end

   initial begin
      int cyc;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_expect(A_ADDR, 8'h00, "R1 addr after reset");
      bus_expect(A_DATA, 8'h00, "R1 data after reset");
      bus_expect(A_CTRL, 8'h00, "R1 ctrl after reset");
      chk("R1 irq after reset", int'(done_irq), 0);

      // R9 full correct sequence inside the lockout window
      bus_write(A_ADDR, 8'h05);
      bus_write(A_DATA, 8'h3C);
      bus_write(A_CTRL, 8'h02);
      bus_write(A_KEY, 8'h55);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h06);
      bus_expect(A_CTRL, 8'h02, "R9 go refused during lockout");
      idle(P);
      bus_write(A_CTRL, 8'h03);
      bus_expect(A_DATA, 8'hFF, "R9 byte 05 still erased");

      // R5/R6 correct write with mid-write disturbance (R8, R10)
      bus_write(A_ADDR, 8'h10);
      bus_write(A_DATA, 8'hA5);
      bus_write(A_KEY, 8'h55);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h06);
      cyc = 0;
      bus_expect(A_CTRL, 8'h06, "R6 go bit set while busy"); cyc++;
      bus_write(A_ADDR, 8'h33); cyc++;
      bus_write(A_DATA, 8'h11); cyc++;
      bus_write(A_CTRL, 8'h00); cyc++;
      bus_expect(A_ADDR, 8'h10, "R10 addr write ignored while busy"); cyc++;
      bus_expect(A_CTRL, 8'h0C, "R10 err set, R8 write continues"); cyc++;
      while (!done_irq && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      chk("R6 cycles from go write to done", cyc, W);
      bus_expect(A_CTRL, 8'h18, "R6 go cleared, R7 done set");
      idle(5);
      bus_expect(A_CTRL, 8'h18, "R7 done sticky");
      chk("R7 irq follows done", int'(done_irq), 1);
      bus_write(A_CTRL, 8'h18);
      bus_expect(A_CTRL, 8'h00, "R7 done and err cleared by writing 1");
      chk("R7 irq low after clear", int'(done_irq), 0);

      // R2 read-back and R3 data hold
      bus_write(A_CTRL, 8'h01);
      bus_expect(A_DATA, 8'hA5, "R2 read-back of stored byte");
      bus_expect(A_CTRL, 8'h00, "R2 read bit reads zero");
      bus_write(A_ADDR, 8'h00);
      bus_expect(A_DATA, 8'hA5, "R3 data kept across address change");
      bus_write(A_DATA, 8'h77);
      bus_expect(A_DATA, 8'h77, "R3 direct data write");

      // R5 broken unlock sequences
      bus_write(A_ADDR, 8'h20);
      bus_write(A_DATA, 8'h5A);
      bus_write(A_CTRL, 8'h02);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_KEY, 8'h55);
      bus_write(A_CTRL, 8'h06);
      bus_expect(A_CTRL, 8'h02, "R5 reversed keys refused");
      bus_write(A_KEY, 8'h55);
      idle(1);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h06);
      bus_expect(A_CTRL, 8'h02, "R5 idle gap refused");
      bus_write(A_KEY, 8'h55);
      bus_expect(A_KEY, 8'h00, "R11 unlock port reads zero");
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h06);
      bus_expect(A_CTRL, 8'h02, "R5 read between keys refused");

      // R4 enable missing
      bus_write(A_CTRL, 8'h00);
      bus_write(A_KEY, 8'h55);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h04);
      bus_expect(A_CTRL, 8'h00, "R4 go without enable refused");
      bus_write(A_KEY, 8'h55);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h06);
      bus_expect(A_CTRL, 8'h02, "R4 enable and go together refused");
      idle(W + 2);
      bus_write(A_CTRL, 8'h03);
      bus_expect(A_DATA, 8'hFF, "R5 byte 20 untouched by refused goes");

      // R10 read request ignored while busy, R8 enable kept
      bus_write(A_DATA, 8'h5A);
      bus_write(A_KEY, 8'h55);
      bus_write(A_KEY, 8'hAA);
      bus_write(A_CTRL, 8'h06);
      bus_write(A_CTRL, 8'h07);
      bus_expect(A_DATA, 8'h5A, "R10 read request ignored while busy");
      bus_expect(A_CTRL, 8'h0E, "R10 err set by read request");
      cyc = 0;
      while (!done_irq && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      chk("R7 irq after second write", int'(done_irq), 1);
      bus_expect(A_CTRL, 8'h1A, "R8 enable kept after completion");
      bus_write(A_CTRL, 8'h1A);
      bus_expect(A_CTRL, 8'h02, "R7 flags cleared, enable kept");
      bus_write(A_CTRL, 8'h03);
      bus_expect(A_DATA, 8'h5A, "R6 second byte stored");

      idle(3);
      chk("scoreboard drained", sb_q.size(), 0);
      finish_run();
   end

endmodule